// File: doc/BRIEF.md
# Q3.12 Fixed-Point Add/Multiply Unit

This block adds or multiplies signed 16-bit fixed-point words. Each word has one sign bit, three integer bits and twelve fraction bits, in two's complement. The caller presents operand A on one channel and operand B on a second channel. Each channel uses a valid/ready handshake. An operation bit rides along with operand A: 0 selects addition and 1 selects multiplication. The result leaves through a third valid/ready channel.

Each channel is backed by a small FIFO that works in pipeline mode. In that mode a full FIFO still accepts a new word in a cycle where its head word is taken. A single compute stage pairs the head of the A queue with the head of the B queue. It fires only when both queues hold a word and the result queue can take one. When it fires, it computes in one cycle, pops both heads and pushes the result, all at the same edge. When it cannot fire, nothing changes. Sum and product both wrap on overflow. Neither rounds nor saturates.

The parameters set the integer and fraction widths and each queue's depth. The defaults give the 16-bit Q3.12 format and two-entry queues.

Top module: `fxq_arith_unit`

## Requirements
- R1: After reset, r_valid is 0 and both a_ready and b_ready are 1.
- R2: With a_op = 0, the result is the 16-bit two's-complement sum of the two raw operand words. It wraps modulo 2^16 (0xCC00 + 0x2A00 = 0xF600, 0x7FFF + 0x0001 = 0x8000).
- R3: With a_op = 1, both operands are sign-extended to 32 bits and multiplied. The result is bits [27:12] of the product, with overflow wrapping (0xF800 × 0x1800 = 0xF400, 0x7FFF × 0x7FFF = 0xFFF0, 0x8000 × 0x8000 = 0x0000).
- R4: The operation bit travels with its own operand A. Pairs with different operations may follow each other back to back, and each one gets its own operation.
- R5: The k-th accepted A word pairs with the k-th accepted B word. Results leave in acceptance order.
- R6: A result is produced only when both operand queues hold a word. An A word with no matching B word yields no result. The count of results never exceeds the count of either operand.
- R7: While r_valid is 1 and r_ready is 0, r_valid stays 1 and r_data holds its value, and no result is lost.
- R8: When all queues are empty, a pair accepted at clock edge k appears on r_valid after edge k+1 and not before.
- R9: An operand queue of two entries deasserts its ready once it holds two words and the compute stage cannot fire. It reasserts ready in a cycle where the stage pops it, even while it is full.
- R10: With the result side always ready, back-to-back pairs produce one result per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Operand A word offered |
| a_ready | output | 1 | Operand A queue can accept |
| a_data | input | 16 | Operand A, Q3.12 |
| a_op | input | 1 | Operation for this pair: 0 add, 1 multiply |
| b_valid | input | 1 | Operand B word offered |
| b_ready | output | 1 | Operand B queue can accept |
| b_data | input | 16 | Operand B, Q3.12 |
| r_valid | output | 1 | Result word available |
| r_ready | input | 1 | Consumer takes the result |
| r_data | output | 16 | Result, Q3.12 |

## Verification
A queue pointer that slips, or an occupancy count that drifts, shows up at the result port. Results then come out paired with the wrong partner or in the wrong order, or a stale word repeats. This is visible on the first result after the fault, two edges after the pair that exposes it.

A fire condition that ignores an empty queue gives a result with no matching operand. The check on cumulative handshake counts catches this in the same cycle. A fire condition that ignores a full result queue drops a word, and the bench sees this when it drains the queue. Wrong arithmetic or wrong bit selection shows in the first result that uses the affected operation.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
   typedef enum logic {
      FXQ_OP_ADD = 1'b0,
      FXQ_OP_MUL = 1'b1
   } fxq_op_e;
endpackage

// File: rtl/fxq_fifo.sv
module fxq_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   output logic             push_ready,
   input  logic [WIDTH-1:0] push_data,
   output logic             pop_valid,
   input  logic             pop_ready,
   output logic [WIDTH-1:0] pop_data
);
   logic pop_fire;
   logic push_fire;

   assign pop_fire  = pop_valid && pop_ready;
   assign push_fire = push_valid && push_ready;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("fxq_fifo: DEPTH must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fxq_fifo: WIDTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic             full_q;
         logic [WIDTH-1:0] word_q;

         assign pop_valid  = full_q;
         assign pop_data   = word_q;
         assign push_ready = !full_q || pop_fire;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               word_q <= '0;
            end else begin
               if (push_fire) begin
                  full_q <= 1'b1;
                  word_q <= push_data;
               end else if (pop_fire) begin
                  full_q <= 1'b0;
               end
            end
         end
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);

         logic [WIDTH-1:0] mem_q [DEPTH];
         logic [PW-1:0]    rd_q;
         logic [PW-1:0]    wr_q;
         logic [CW-1:0]    cnt_q;
         logic             full_w;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         assign full_w     = (cnt_q == CW'(DEPTH));
         assign pop_valid  = (cnt_q != '0);
         assign pop_data   = mem_q[rd_q];
         assign push_ready = !full_w || pop_fire;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (push_fire) begin
                  mem_q[wr_q] <= push_data;
                  wr_q        <= step(wr_q);
               end
               if (pop_fire) rd_q <= step(rd_q);
               if (push_fire && !pop_fire)      cnt_q <= cnt_q + CW'(1);
               else if (pop_fire && !push_fire) cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fxq_alu.sv
module fxq_alu
   import fxq_pkg::*;
#(
   parameter int INT_BITS  = 3,
   parameter int FRAC_BITS = 12
) (
   input  fxq_op_e                        op,
   input  logic [INT_BITS+FRAC_BITS:0]    opa,
   input  logic [INT_BITS+FRAC_BITS:0]    opb,
   output logic [INT_BITS+FRAC_BITS:0]    res
);
   localparam int W  = 1 + INT_BITS + FRAC_BITS;
   localparam int DW = 2 * W;

   generate
      if (INT_BITS < 0 || FRAC_BITS < 1) begin : g_bad_fmt
         $error("fxq_alu: need INT_BITS >= 0 and FRAC_BITS >= 1");
      end
   endgenerate

   logic [DW-1:0] ext_a;
   logic [DW-1:0] ext_b;
   logic [DW-1:0] prod;
   logic [W-1:0]  sum;

   assign ext_a = {{W{opa[W-1]}}, opa};
   assign ext_b = {{W{opb[W-1]}}, opb};
   assign prod  = ext_a * ext_b;
   assign sum   = opa + opb;

   always_comb begin
      unique case (op)
         FXQ_OP_MUL: res = prod[FRAC_BITS+W-1:FRAC_BITS];
         default:    res = sum;
      endcase
   end
endmodule

// File: rtl/fxq_arith_unit.sv
module fxq_arith_unit
   import fxq_pkg::*;
#(
   parameter int INT_BITS  = 3,
   parameter int FRAC_BITS = 12,
   parameter int A_DEPTH   = 2,
   parameter int B_DEPTH   = 2,
   parameter int R_DEPTH   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        a_valid,
   output logic                        a_ready,
   input  logic [INT_BITS+FRAC_BITS:0] a_data,
   input  logic                        a_op,
   input  logic                        b_valid,
   output logic                        b_ready,
   input  logic [INT_BITS+FRAC_BITS:0] b_data,
   output logic                        r_valid,
   input  logic                        r_ready,
   output logic [INT_BITS+FRAC_BITS:0] r_data
);
   localparam int W  = 1 + INT_BITS + FRAC_BITS;
   localparam int AW = W + 1;

   logic          a_head_v;
   logic [AW-1:0] a_head;
   logic          b_head_v;
   logic [W-1:0]  b_head;
   logic          r_slot;
   logic [W-1:0]  alu_res;
   logic          fire;

   assign fire = a_head_v && b_head_v && r_slot;

   fxq_fifo #(.WIDTH(AW), .DEPTH(A_DEPTH)) u_qa (
      .clk(clk), .rst_n(rst_n),
      .push_valid(a_valid), .push_ready(a_ready), .push_data({a_op, a_data}),
      .pop_valid(a_head_v), .pop_ready(fire), .pop_data(a_head)
   );

   fxq_fifo #(.WIDTH(W), .DEPTH(B_DEPTH)) u_qb (
      .clk(clk), .rst_n(rst_n),
      .push_valid(b_valid), .push_ready(b_ready), .push_data(b_data),
      .pop_valid(b_head_v), .pop_ready(fire), .pop_data(b_head)
   );

   fxq_alu #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_alu (
      .op(fxq_op_e'(a_head[AW-1])),
      .opa(a_head[W-1:0]),
      .opb(b_head),
      .res(alu_res)
   );

   fxq_fifo #(.WIDTH(W), .DEPTH(R_DEPTH)) u_qr (
      .clk(clk), .rst_n(rst_n),
      .push_valid(fire), .push_ready(r_slot), .push_data(alu_res),
      .pop_valid(r_valid), .pop_ready(r_ready), .pop_data(r_data)
   );
endmodule

// File: rtl/fxq_arith_chk.sv
module fxq_arith_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         a_valid,
   input logic         a_ready,
   input logic         b_valid,
   input logic         b_ready,
   input logic         r_valid,
   input logic         r_ready,
   input logic [W-1:0] r_data,
   input logic         fire
);
   logic [31:0] na_q, nb_q, nr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         na_q <= '0;
         nb_q <= '0;
         nr_q <= '0;
      end else begin
         if (a_valid && a_ready) na_q <= na_q + 32'd1;
         if (b_valid && b_ready) nb_q <= nb_q + 32'd1;
         if (r_valid && r_ready) nr_q <= nr_q + 32'd1;
      end
   end

   AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> r_valid); // R7
   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_ready) |=> $stable(r_data)); // R7
   AST_NO_LONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (nr_q <= na_q) && (nr_q <= nb_q)); // R6
   AST_FIRE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> r_valid); // R8
endmodule

bind fxq_arith_unit fxq_arith_chk #(.W(W)) u_fxq_chk (
   .clk(clk), .rst_n(rst_n),
   .a_valid(a_valid), .a_ready(a_ready),
   .b_valid(b_valid), .b_ready(b_ready),
   .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
   .fire(fire)
);

// File: tb/test_fxq_arith_unit.sv
module test_fxq_arith_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_valid = 1'b0, a_op = 1'b0, b_valid = 1'b0, r_ready = 1'b0;
   logic [15:0] a_data = '0, b_data = '0;
   logic        a_ready, b_ready, r_valid;
   logic [15:0] r_data;
   int          total = 0, bad = 0;

   always #4 clk = ~clk;

   fxq_arith_unit i_fxq_arith_unit (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_op(a_op),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
   );

   function automatic logic [15:0] model(input logic op, input logic [15:0] a, input logic [15:0] b);
      logic signed [31:0] p;
      if (!op) return a + b;
      p = $signed(a) * $signed(b);
      return p[27:12];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_a(input logic [15:0] d, input logic op);
      a_valid = 1'b1; a_data = d; a_op = op;
      while (!a_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      a_valid = 1'b0;
   endtask

   task automatic send_b(input logic [15:0] d);
      b_valid = 1'b1; b_data = d;
      while (!b_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      b_valid = 1'b0;
   endtask

   task automatic send_pair(input logic [15:0] a, input logic [15:0] b, input logic op);
      fork
         send_a(a, op);
         send_b(b);
      join
   endtask

   task automatic get_res(output logic [15:0] d);
      r_ready = 1'b1;
      while (!r_valid) @(negedge clk);
      d = r_data;
      @(posedge clk);
      @(negedge clk);
      r_ready = 1'b0;
   endtask

   task automatic one_op(input logic [15:0] a, input logic [15:0] b, input logic op, input string tag);
      logic [15:0] got;
      send_pair(a, b, op);
      get_res(got);
      chk(got == model(op, a, b), tag, got, model(op, a, b));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(r_valid == 1'b0, "R1 r_valid", r_valid, 0);
      chk(a_ready && b_ready, "R1 ready", {a_ready, b_ready}, 2'b11);
   endtask

   task automatic t_add;
      one_op(16'hCC00, 16'h2A00, 1'b0, "R2 add -3.25+2.625");
      one_op(16'h7FFF, 16'h0001, 1'b0, "R2 add wrap");
      one_op(16'h8000, 16'hFFFF, 1'b0, "R2 add neg wrap");
   endtask

   task automatic t_mul;
      one_op(16'hF800, 16'h1800, 1'b1, "R3 mul -0.5*1.5");
      one_op(16'h7FFF, 16'h7FFF, 1'b1, "R3 mul max");
      one_op(16'h8000, 16'h8000, 1'b1, "R3 mul min*min");
      one_op(16'h1000, 16'h1234, 1'b1, "R3 mul by one");
   endtask

   task automatic t_mixed_order;
      logic [15:0] got;
      r_ready = 1'b0;
      send_pair(16'hF800, 16'h1800, 1'b1);
      send_pair(16'hCC00, 16'h2A00, 1'b0);
      send_pair(16'h2000, 16'hE000, 1'b1);
      get_res(got);
      chk(got == 16'hF400, "R4 R5 first mul", got, 16'hF400);
      get_res(got);
      chk(got == 16'hF600, "R4 R5 second add", got, 16'hF600);
      get_res(got);
      chk(got == model(1'b1, 16'h2000, 16'hE000), "R5 third after stall", got, model(1'b1, 16'h2000, 16'hE000));
   endtask

   task automatic t_lone_a;
      logic [15:0] got;
      r_ready = 1'b1;
      send_a(16'h0100, 1'b0);
      send_a(16'h0200, 1'b0);
      repeat (4) @(negedge clk);
      chk(r_valid == 1'b0, "R6 no result without B", r_valid, 0);
      chk(a_ready == 1'b0, "R9 full queue not ready", a_ready, 0);
      r_ready = 1'b0;
      send_b(16'h0001);
      chk(a_ready == 1'b1, "R9 ready while popping", a_ready, 1);
      send_b(16'h0002);
      get_res(got);
      chk(got == 16'h0101, "R5 lone pair 1", got, 16'h0101);
      get_res(got);
      chk(got == 16'h0202, "R5 lone pair 2", got, 16'h0202);
   endtask

   task automatic t_backpressure;
      logic [15:0] held, got;
      bit ok = 1'b1;
      r_ready = 1'b0;
      send_pair(16'h1111, 16'h2222, 1'b0);
      while (!r_valid) @(negedge clk);
      held = r_data;
      repeat (4) begin
         @(negedge clk);
         if (!r_valid || r_data != held) ok = 1'b0;
      end
      chk(ok, "R7 held under backpressure", {r_valid, r_data}, {1'b1, held});
      get_res(got);
      chk(got == 16'h3333, "R7 value after release", got, 16'h3333);
   endtask

   task automatic t_latency;
      logic [15:0] got;
      r_ready = 1'b0;
      @(negedge clk);
      a_valid = 1'b1; a_data = 16'h0400; a_op = 1'b0;
      b_valid = 1'b1; b_data = 16'h0300;
      @(posedge clk);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
      chk(r_valid == 1'b0, "R8 not after one edge", r_valid, 0);
      @(negedge clk);
      chk(r_valid == 1'b1, "R8 valid after two edges", r_valid, 1);
      get_res(got);
      chk(got == 16'h0700, "R8 value", got, 16'h0700);
   endtask

   task automatic t_stream;
      logic [15:0] exp [8];
      int hits = 0;
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++) exp[i] = model(i[0], 16'(16'h0180 * i), 16'(16'h1000 + 16'h0040 * i));
      r_ready = 1'b1;
      fork
         for (int i = 0; i < 8; i++) send_pair(16'(16'h0180 * i), 16'(16'h1000 + 16'h0040 * i), i[0]);
         begin
            while (!r_valid) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               if (r_valid) hits++;
               if (!r_valid || r_data != exp[i]) ok = 1'b0;
               @(negedge clk);
            end
         end
      join
      r_ready = 1'b0;
      chk(hits == 8, "R10 one result per cycle", hits, 8);
      chk(ok, "R10 R4 stream values", ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_add();
      t_mul();
      t_mixed_order();
      t_lone_a();
      t_backpressure();
      t_latency();
      t_stream();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule